// File: doc/BRIEF.md
# Cursor Overlay and Pixel Edit Datapath

This block sits between the frame memory and the LED line drivers of a small two-colour pixel sketch pad. A scan counter elsewhere presents one 8-bit line segment per slot together with its segment address. The address packs, from the least significant bit up, a colour bit (0 = red byte, 1 = green byte), a half bit (0 = pixels 0..7, 1 = pixels 8..15) and a line number. The block builds a one-hot cursor mask for that slot from the cursor X/Y position and the selected palette. It combines the mask with the segment data through one of five bitwise functions, then returns a registered display byte. The same byte doubles as the write-back data when the write enable is raised.

Function codes: 0110 show (data XOR mask), 0111 hole (data AND NOT mask), 1110 dot (data OR mask), 1111 pass (data), 0011 zero. An edit state machine handles the actions that span a frame. Its states are ST_IDLE, ST_CLR_WAIT, ST_CLR_RUN, ST_DOT_WAIT and ST_DOT_RUN. In ST_IDLE a clear request moves it to ST_CLR_WAIT. Otherwise a draw or erase button moves it to ST_DOT_WAIT, and the erase button wins if both are pressed. A WAIT state moves to its RUN state on the slot at address 0, and that slot is already acted upon. A RUN state returns to ST_IDLE on the slot at the last address. Playback mode sends any state back to ST_IDLE. A frame counter toggles the cursor blink.

Top module: `cursor_overlay`

## Requirements
- R1: While reset is asserted and before the first slot, out_valid, wr_en and disp_data are all zero.
- R2: out_valid is high exactly in the cycle after a cycle with seg_valid high; with seg_valid low, the next cycle has out_valid and wr_en low.
- R3: In edit mode with the blink lit and no write active, disp_data = seg_data XOR mask and wr_en is 0.
- R4: The mask has the single bit cur_x[2:0] set only when cur_y equals the line number, cur_x[3] equals the half bit, and the colour bit is enabled by color_sel (bit0 enables red, bit1 enables green, 11 = yellow enables both, 00 = none); otherwise it is zero.
- R5: The blink is dark from reset and toggles after every BLINK_FRAMES completed frames (a frame ends with the slot at the all-ones address); while dark, disp_data = seg_data.
- R6: In playback mode disp_data = seg_data in every slot and wr_en stays 0, whatever the draw, erase, button and clear inputs do.
- R7: With draw_cont held, a slot with a non-zero mask gives disp_data = seg_data OR mask with wr_en = 1; slots with a zero mask give seg_data with wr_en = 0.
- R8: With erase_cont held, a slot with a non-zero mask gives disp_data = seg_data AND NOT mask with wr_en = 1.
- R9: With draw and erase both active, erase wins.
- R10: A clear_req pulse seen in ST_IDLE makes every slot of the next frame, from address 0 through the last address, output zero with wr_en = 1; the frame after that is back to normal.
- R11: A draw_btn or erase_btn pulse seen in ST_IDLE applies the dot or hole write to the slots of exactly one following frame, starting at address 0, and then ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| seg_valid | input | 1 | A segment slot is presented this cycle |
| seg_addr | input | LINE_W+2 | Segment address: bit0 colour, bit1 half, upper bits line |
| seg_data | input | DW | Segment byte read from memory |
| cur_x | input | log2(DW)+1 | Cursor column (top bit picks the half) |
| cur_y | input | LINE_W | Cursor line |
| color_sel | input | 2 | Palette: bit0 red, bit1 green |
| playback | input | 1 | Playback mode, cursor and edits off |
| draw_cont | input | 1 | Continuous draw level |
| erase_cont | input | 1 | Continuous erase level |
| draw_btn | input | 1 | Single-dot draw request pulse |
| erase_btn | input | 1 | Single-dot erase request pulse |
| clear_req | input | 1 | Page clear request pulse |
| out_valid | output | 1 | Result of the previous slot is on disp_data |
| disp_data | output | DW | Display byte, also the write-back data |
| wr_en | output | 1 | Write disp_data back to the slot's address |

## Verification
The bench targets the mask qualifiers: the high-half column, the yellow palette and the empty palette. A design that ignored the half bit or a colour bit would mark the cursor, or write, in the wrong byte. The bench drives whole frames across the blink boundary, so a blink with the wrong phase or period shows as XOR patterns in dark frames. It runs playback with draw held, where a leaky gate would write or reveal the cursor. It runs clear and single-dot actions, and checks the frame after each one. A state machine that started mid-frame, or never returned to idle, would miss address 0 or keep writing.

// File: rtl/cov_pkg.sv
package cov_pkg;
    typedef enum logic [3:0] {
        OP_SHOW = 4'b0110,
        OP_HOLE = 4'b0111,
        OP_DOT  = 4'b1110,
        OP_PASS = 4'b1111,
        OP_ZERO = 4'b0011
    } seg_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLR_WAIT,
        ST_CLR_RUN,
        ST_DOT_WAIT,
        ST_DOT_RUN
    } edit_st_e;
endpackage

// File: rtl/ovl_mask_dec.sv
module ovl_mask_dec #(
    parameter int DW     = 8,
    parameter int LINE_W = 4,
    localparam int PW    = $clog2(DW),
    localparam int XW    = PW + 1
) (
    input  logic [LINE_W-1:0] line_addr,
    input  logic              half_sel,
    input  logic              color_bit,
    input  logic [XW-1:0]     cur_x,
    input  logic [LINE_W-1:0] cur_y,
    input  logic [1:0]        color_sel,
    output logic [DW-1:0]     mask
);
    logic line_hit;
    logic half_hit;
    logic color_hit;
    logic slot_hit;

    always_comb begin
        line_hit  = (cur_y == line_addr);
        half_hit  = (cur_x[XW-1] == half_sel);
        color_hit = color_bit ? color_sel[1] : color_sel[0];
        slot_hit  = line_hit && half_hit && color_hit;
    end

    for (genvar g = 0; g < DW; g++) begin : g_bit
        assign mask[g] = slot_hit && (cur_x[PW-1:0] == PW'(g));
    end
endmodule

// File: rtl/ovl_seg_alu.sv
module ovl_seg_alu
    import cov_pkg::*;
#(
    parameter int DW = 8
) (
    input  seg_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] f
);
    always_comb begin
        unique case (op)
            OP_SHOW: f = a ^ b;
            OP_HOLE: f = a & ~b;
            OP_DOT:  f = a | b;
            OP_ZERO: f = '0;
            default: f = a;
        endcase
    end
endmodule

// File: rtl/ovl_blink.sv
module ovl_blink #(
    parameter int BLINK_FRAMES = 30,
    localparam int CW = $clog2(BLINK_FRAMES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_end,
    output logic blink_on
);
    logic [CW-1:0] frame_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_cnt <= '0;
            blink_on  <= 1'b0;
        end else if (frame_end) begin
            if (frame_cnt == CW'(BLINK_FRAMES - 1)) begin
                frame_cnt <= '0;
                blink_on  <= ~blink_on;
            end else begin
                frame_cnt <= frame_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/ovl_edit_fsm.sv
module ovl_edit_fsm
    import cov_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic playback,
    input  logic clear_req,
    input  logic draw_btn,
    input  logic erase_btn,
    input  logic seg_valid,
    input  logic frame_start,
    input  logic frame_end,
    output logic clr_now,
    output logic dot_draw_now,
    output logic dot_erase_now
);
    edit_st_e state;
    edit_st_e state_nx;
    logic     dot_erase_q;
    logic     take_btn;

    assign take_btn = (state == ST_IDLE) && !playback && !clear_req
                      && (draw_btn || erase_btn);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            dot_erase_q <= 1'b0;
        end else begin
            state <= state_nx;
            if (take_btn) begin
                dot_erase_q <= erase_btn;
            end
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (playback)       state_nx = ST_IDLE;
                else if (clear_req) state_nx = ST_CLR_WAIT;
                else if (draw_btn || erase_btn) state_nx = ST_DOT_WAIT;
            end
            ST_CLR_WAIT: begin
                if (playback) state_nx = ST_IDLE;
                else if (seg_valid && frame_start) state_nx = ST_CLR_RUN;
            end
            ST_CLR_RUN: begin
                if (playback || (seg_valid && frame_end)) state_nx = ST_IDLE;
            end
            ST_DOT_WAIT: begin
                if (playback) state_nx = ST_IDLE;
                else if (seg_valid && frame_start) state_nx = ST_DOT_RUN;
            end
            ST_DOT_RUN: begin
                if (playback || (seg_valid && frame_end)) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        logic act_slot;
        logic dot_slot;
        act_slot = seg_valid && !playback;
        clr_now  = act_slot && ((state == ST_CLR_RUN)
                   || ((state == ST_CLR_WAIT) && frame_start));
        dot_slot = act_slot && ((state == ST_DOT_RUN)
                   || ((state == ST_DOT_WAIT) && frame_start));
        dot_draw_now  = dot_slot && !dot_erase_q;
        dot_erase_now = dot_slot && dot_erase_q;
    end
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
    import cov_pkg::*;
#(
    parameter int DW           = 8,
    parameter int LINE_W       = 4,
    parameter int BLINK_FRAMES = 30,
    localparam int PW          = $clog2(DW),
    localparam int XW          = PW + 1,
    localparam int AW          = LINE_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seg_valid,
    input  logic [AW-1:0]     seg_addr,
    input  logic [DW-1:0]     seg_data,
    input  logic [XW-1:0]     cur_x,
    input  logic [LINE_W-1:0] cur_y,
    input  logic [1:0]        color_sel,
    input  logic              playback,
    input  logic              draw_cont,
    input  logic              erase_cont,
    input  logic              draw_btn,
    input  logic              erase_btn,
    input  logic              clear_req,
    output logic              out_valid,
    output logic [DW-1:0]     disp_data,
    output logic              wr_en
);
    logic          frame_start;
    logic          frame_end;
    logic          blink_on;
    logic [DW-1:0] mask;
    logic          mask_hit;
    logic          clr_slot;
    logic          dot_draw;
    logic          dot_erase;
    logic          do_draw;
    logic          do_erase;
    logic          wr_slot;
    seg_op_e       op_sel;
    logic [DW-1:0] alu_f;

    assign frame_start = (seg_addr == '0);
    assign frame_end   = seg_valid && (seg_addr == '1);

    ovl_mask_dec #(.DW(DW), .LINE_W(LINE_W)) u_mask (
        .line_addr (seg_addr[AW-1:2]),
        .half_sel  (seg_addr[1]),
        .color_bit (seg_addr[0]),
        .cur_x     (cur_x),
        .cur_y     (cur_y),
        .color_sel (color_sel),
        .mask      (mask)
    );

    ovl_blink #(.BLINK_FRAMES(BLINK_FRAMES)) u_blink (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_end (frame_end),
        .blink_on  (blink_on)
    );

    ovl_edit_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .playback      (playback),
        .clear_req     (clear_req),
        .draw_btn      (draw_btn),
        .erase_btn     (erase_btn),
        .seg_valid     (seg_valid),
        .frame_start   (frame_start),
        .frame_end     (frame_end),
        .clr_now       (clr_slot),
        .dot_draw_now  (dot_draw),
        .dot_erase_now (dot_erase)
    );

    always_comb begin
        mask_hit = |mask;
        do_erase = !playback && (erase_cont || dot_erase);
        do_draw  = !playback && (draw_cont || dot_draw);
        if (playback)                  op_sel = OP_PASS;
        else if (clr_slot)             op_sel = OP_ZERO;
        else if (do_erase && mask_hit) op_sel = OP_HOLE;
        else if (do_draw && mask_hit)  op_sel = OP_DOT;
        else if (blink_on)             op_sel = OP_SHOW;
        else                           op_sel = OP_PASS;
        wr_slot = seg_valid && (clr_slot || ((do_erase || do_draw) && mask_hit));
    end

    ovl_seg_alu #(.DW(DW)) u_alu (
        .op (op_sel),
        .a  (seg_data),
        .b  (mask),
        .f  (alu_f)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            wr_en     <= 1'b0;
            disp_data <= '0;
        end else begin
            out_valid <= seg_valid;
            wr_en     <= wr_slot;
            if (seg_valid) begin
                disp_data <= alu_f;
            end
        end
    end
endmodule

// File: rtl/ovl_checker.sv
module ovl_checker #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          seg_valid,
    input logic [DW-1:0] seg_data,
    input logic          playback,
    input logic          clr_slot,
    input logic          mask_hit,
    input logic          out_valid,
    input logic          wr_en,
    input logic [DW-1:0] disp_data
);
    p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid |=> out_valid);

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !seg_valid |=> (!out_valid && !wr_en));

    p_hit_needed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_valid && !mask_hit && !clr_slot) |=> !wr_en);

    p_playback_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_valid && playback) |=> (!wr_en && disp_data == $past(seg_data)));

    p_clear_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_slot |=> (wr_en && disp_data == '0));
endmodule

bind cursor_overlay ovl_checker #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .seg_valid (seg_valid),
    .seg_data  (seg_data),
    .playback  (playback),
    .clr_slot  (clr_slot),
    .mask_hit  (mask_hit),
    .out_valid (out_valid),
    .wr_en     (wr_en),
    .disp_data (disp_data)
);

// File: tb/tb_cursor_overlay.sv
`timescale 1ns/1ps
module tb_cursor_overlay;
    localparam int BF = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       seg_valid = 1'b0;
    logic [5:0] seg_addr = '0;
    logic [7:0] seg_data = '0;
    logic [3:0] cur_x = '0;
    logic [3:0] cur_y = '0;
    logic [1:0] color_sel = 2'b01;
    logic       playback = 1'b0;
    logic       draw_cont = 1'b0;
    logic       erase_cont = 1'b0;
    logic       draw_btn = 1'b0;
    logic       erase_btn = 1'b0;
    logic       clear_req = 1'b0;
    logic       out_valid;
    logic [7:0] disp_data;
    logic       wr_en;

    int n_chk = 0;
    int n_bad = 0;
    int frames = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cursor_overlay #(.BLINK_FRAMES(BF)) dut (
        .clk(clk), .rst_n(rst_n), .seg_valid(seg_valid), .seg_addr(seg_addr),
        .seg_data(seg_data), .cur_x(cur_x), .cur_y(cur_y), .color_sel(color_sel),
        .playback(playback), .draw_cont(draw_cont), .erase_cont(erase_cont),
        .draw_btn(draw_btn), .erase_btn(erase_btn), .clear_req(clear_req),
        .out_valid(out_valid), .disp_data(disp_data), .wr_en(wr_en)
    );

    function automatic logic [7:0] exp_mask(input logic [5:0] a);
        logic col_ok;
        col_ok = a[0] ? color_sel[1] : color_sel[0];
        if (col_ok && (cur_y == a[5:2]) && (cur_x[3] == a[1]))
            return 8'(1) << cur_x[2:0];
        return 8'h00;
    endfunction

    task automatic check(input string tag, input bit ok, input string got, input string exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %s expected %s", tag, got, exp);
        end
    endtask

    task automatic run_frame(input string tag, input bit m_draw, input bit m_erase,
                             input bit m_clr, input logic [7:0] seed);
        bit blink;
        blink = ((frames / BF) % 2) == 1;
        for (int a = 0; a < 64; a++) begin
            logic [7:0] d, m, e;
            logic ew;
            d = (8'(a) * 8'd29 + seed) ^ 8'h5A;
            m = exp_mask(6'(a));
            ew = 1'b0;
            if (playback) e = d;
            else if (m_clr) begin e = 8'h00; ew = 1'b1; end
            else if (m_erase && m != 0) begin e = d & ~m; ew = 1'b1; end
            else if (m_draw && m != 0) begin e = d | m; ew = 1'b1; end
            else if (blink) e = d ^ m;
            else e = d;
            seg_valid = 1'b1;
            seg_addr  = 6'(a);
            seg_data  = d;
            @(negedge clk);
            check($sformatf("%s addr %0d", tag, a),
                  out_valid && disp_data == e && wr_en == ew,
                  $sformatf("v=%0b d=%02h w=%0b", out_valid, disp_data, wr_en),
                  $sformatf("v=1 d=%02h w=%0b", e, ew));
        end
        seg_valid = 1'b0;
        frames++;
        @(negedge clk);
        check({tag, " R2 gap"}, !out_valid && !wr_en,
              $sformatf("v=%0b w=%0b", out_valid, wr_en), "v=0 w=0");
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        if (which == 0) clear_req = 1'b1;
        else if (which == 1) draw_btn = 1'b1;
        else erase_btn = 1'b1;
        @(negedge clk);
        clear_req = 1'b0;
        draw_btn  = 1'b0;
        erase_btn = 1'b0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R1 in reset", !out_valid && !wr_en && disp_data == 0,
              $sformatf("v=%0b w=%0b d=%02h", out_valid, wr_en, disp_data), "all zero");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", !out_valid && !wr_en && disp_data == 0,
              $sformatf("v=%0b w=%0b d=%02h", out_valid, wr_en, disp_data), "all zero");
    endtask

    task automatic t_blink();
        cur_x = 4'd5; cur_y = 4'd3; color_sel = 2'b01;
        run_frame("R5 dark frame 0", 0, 0, 0, 8'h11);
        run_frame("R5 dark frame 1", 0, 0, 0, 8'h22);
        run_frame("R3 lit red", 0, 0, 0, 8'h33);
        cur_x = 4'd12; cur_y = 4'd15; color_sel = 2'b00;
        run_frame("R4 no palette", 0, 0, 0, 8'h44);
    endtask

    task automatic t_cont();
        cur_x = 4'd11; cur_y = 4'd7; color_sel = 2'b10;
        draw_cont = 1'b1;
        run_frame("R7 draw green high half", 1, 0, 0, 8'h00);
        draw_cont = 1'b0; erase_cont = 1'b1;
        run_frame("R8 erase green", 0, 1, 0, 8'hFF);
        draw_cont = 1'b1; color_sel = 2'b11;
        run_frame("R9 both yellow", 1, 1, 0, 8'hA5);
        erase_cont = 1'b0;
        playback = 1'b1;
        run_frame("R6 playback draw held", 0, 0, 0, 8'h3C);
        draw_cont = 1'b0;
        playback = 1'b0;
    endtask

    task automatic t_clear();
        cur_x = 4'd2; cur_y = 4'd9; color_sel = 2'b11;
        pulse(0);
        run_frame("R10 clear frame", 0, 0, 1, 8'h77);
        run_frame("R10 after clear", 0, 0, 0, 8'h78);
    endtask

    task automatic t_dot();
        cur_x = 4'd0; cur_y = 4'd0; color_sel = 2'b11;
        pulse(1);
        run_frame("R11 draw dot", 1, 0, 0, 8'h00);
        run_frame("R11 after draw dot", 0, 0, 0, 8'h01);
        cur_x = 4'd15; cur_y = 4'd15; color_sel = 2'b01;
        pulse(2);
        run_frame("R11 erase dot", 0, 1, 0, 8'hFF);
        run_frame("R11 after erase dot", 0, 0, 0, 8'hFE);
        playback = 1'b1;
        pulse(0);
        pulse(1);
        playback = 1'b0;
        run_frame("R6 requests in playback ignored", 0, 0, 0, 8'h5D);
    endtask

    initial begin
        t_reset();
        t_blink();
        t_cont();
        t_clear();
        t_dot();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule